// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block keeps a small set-associative store of page table entries and turns a virtual page number into a physical page number within the same cycle. Every entry is tagged with the identifier of the process that owns it, so translations for several processes can be held together and a lookup never returns another process's mapping. A lookup presents a full virtual address with the current process identifier. On a hit the block returns the physical address: the stored physical page number joined to the unchanged page-offset bits. On a miss it raises a miss request that carries the virtual page number. Whatever walks the page tables then returns the entry through the refill port.

The set is selected by the low `IDX_W` bits of the virtual page number. The remaining upper bits form the stored tag. A refill either updates a matching entry in place or claims a way in the selected set. The way is the lowest invalid one, or, when the set is full, the one named by that set's round-robin pointer. A single-cycle flush drops every entry at a context switch. The block holds no sequencing state: its only state is the entry array and the per-set replacement pointers. Lookups are purely combinational over that state, and refills and flushes act at the clock edge.

Top module: `ptag_tlb`

## Requirements
- R1: With `lk_valid` high, `hit` rises in the same cycle when a valid entry in set `vpn[IDX_W-1:0]` holds tag `vpn[VPN_W-1:IDX_W]` and the presented process identifier. `paddr` is then `{ppn, lk_vaddr[OFF_W-1:0]}`, where vpn is `lk_vaddr[VA_W-1:OFF_W]`.
- R2: An entry whose process identifier differs from `lk_pid` never produces a hit, even when its tag and set match.
- R3: `miss_req` is high exactly when `lk_valid` is high and there is no hit, and `miss_vpn` then equals the looked-up virtual page number. With `lk_valid` low, both `hit` and `miss_req` are low.
- R4: A refill (`fill_valid` high) installs its entry at the clock edge, so the entry is visible to lookups from the next cycle on. A lookup in the same cycle as the refill sees the contents from before the refill.
- R5: A refill whose set, tag and process identifier match a valid entry overwrites that entry's physical page number and creates no second copy.
- R6: A refill that matches no entry goes into the lowest-numbered invalid way of its set.
- R7: When all ways of the set are valid, the victim is the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping, after each such replacement.
- R8: `flush` invalidates every entry at one clock edge, and every lookup in the following cycle misses. A refill presented in the same cycle as a flush is discarded.
- R9: After reset, all entries are invalid and every replacement pointer is at way 0.
- R10: A refill into one set leaves the entries of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_pid | input | PID_W | Process identifier of the lookup |
| hit | output | 1 | Translation found |
| paddr | output | PPN_W+OFF_W | Physical address, meaningful when hit is high |
| miss_req | output | 1 | Lookup missed; entry must be fetched |
| miss_vpn | output | VPN_W | Virtual page number of the missing entry |
| fill_valid | input | 1 | Install an entry at this clock edge |
| fill_vpn | input | VPN_W | Virtual page number of the refill |
| fill_pid | input | PID_W | Process identifier of the refill |
| fill_ppn | input | PPN_W | Physical page number of the refill |
| flush | input | 1 | Invalidate all entries |

## Verification
The same virtual page is looked up under two process identifiers, first after only one of them has been installed and then after both. This separates a process-blind tag match from a correct one. A set is filled past its capacity, and the bench then checks which earlier pages still hit. That shows whether the victim came from the free-way search or from the rotating pointer, and whether the pointer moves past each way in turn. A repeated refill of an existing page with a new frame number tells an in-place update from a duplicate entry, because the lowest matching way would still return the old frame. The remaining lookups cover neighbouring sets, equal set bits with a different tag, a flush, a flush that coincides with a refill, and a lookup that coincides with a refill.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;
    typedef enum logic [1:0] {
        VSEL_MATCH = 2'd0,
        VSEL_FREE  = 2'd1,
        VSEL_RR    = 2'd2
    } vsel_e;
endpackage

// File: rtl/ptag_tlb_match.sv
module ptag_tlb_match #(
    parameter int TAG_W = 18,
    parameter int PID_W = 8,
    parameter int PPN_W = 20,
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0][PID_W-1:0] pids,
    input  logic [WAYS-1:0][PPN_W-1:0] ppns,
    input  logic [TAG_W-1:0]           q_tag,
    input  logic [PID_W-1:0]           q_pid,
    output logic                       any,
    output logic [WAY_W-1:0]           way,
    output logic [PPN_W-1:0]           ppn
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = vld[w] && (tags[w] == q_tag) && (pids[w] == q_pid);
    end

    assign any = |eq;

    // lowest matching way wins
    always_comb begin
        way = '0;
        ppn = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                way = WAY_W'(w);
                ppn = ppns[w];
            end
        end
    end
endmodule

// File: rtl/ptag_tlb_victim.sv
module ptag_tlb_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] rr,
    output logic [WAY_W-1:0] victim,
    output logic             set_full
);
    assign set_full = &vld;

    always_comb begin
        victim = rr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
    import ptag_tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20,
    parameter int PID_W = 8,
    parameter int IDX_W = 2,
    parameter int WAYS  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input  logic [PID_W-1:0]       lk_pid,
    output logic                   hit,
    output logic [PPN_W+OFF_W-1:0] paddr,
    output logic                   miss_req,
    output logic [VPN_W-1:0]       miss_vpn,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PID_W-1:0]       fill_pid,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   flush
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [SETS-1:0][WAYS-1:0]  vld_q;
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0][PID_W-1:0] pid_q [SETS];
    logic [WAYS-1:0][PPN_W-1:0] ppn_q [SETS];
    logic [WAY_W-1:0]           rr_q  [SETS];

    // lookup path
    logic [VPN_W-1:0] lk_vpn;
    logic [IDX_W-1:0] lk_idx;
    logic             lk_any;
    logic [WAY_W-1:0] lk_way;
    logic [PPN_W-1:0] lk_ppn;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_idx = lk_vpn[IDX_W-1:0];

    ptag_tlb_match #(
        .TAG_W(TAG_W), .PID_W(PID_W), .PPN_W(PPN_W), .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_lk_match (
        .vld  (vld_q[lk_idx]),
        .tags (tag_q[lk_idx]),
        .pids (pid_q[lk_idx]),
        .ppns (ppn_q[lk_idx]),
        .q_tag(lk_vpn[VPN_W-1:IDX_W]),
        .q_pid(lk_pid),
        .any  (lk_any),
        .way  (lk_way),
        .ppn  (lk_ppn)
    );

    assign hit      = lk_valid && lk_any;
    assign miss_req = lk_valid && !lk_any;
    assign miss_vpn = lk_vpn;
    assign paddr    = {lk_ppn, lk_vaddr[OFF_W-1:0]};

    // refill path
    logic [IDX_W-1:0] f_idx;
    logic             f_any;
    logic [WAY_W-1:0] f_way;
    logic [PPN_W-1:0] f_old_ppn;
    logic [WAY_W-1:0] f_victim;
    logic             f_full;
    logic [WAY_W-1:0] wr_way;
    logic             do_fill;
    vsel_e            vsel;

    assign f_idx = fill_vpn[IDX_W-1:0];

    ptag_tlb_match #(
        .TAG_W(TAG_W), .PID_W(PID_W), .PPN_W(PPN_W), .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_fill_match (
        .vld  (vld_q[f_idx]),
        .tags (tag_q[f_idx]),
        .pids (pid_q[f_idx]),
        .ppns (ppn_q[f_idx]),
        .q_tag(fill_vpn[VPN_W-1:IDX_W]),
        .q_pid(fill_pid),
        .any  (f_any),
        .way  (f_way),
        .ppn  (f_old_ppn)
    );

    ptag_tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .vld     (vld_q[f_idx]),
        .rr      (rr_q[f_idx]),
        .victim  (f_victim),
        .set_full(f_full)
    );

    assign do_fill = fill_valid && !flush;

    always_comb begin
        if (f_any)       vsel = VSEL_MATCH;
        else if (f_full) vsel = VSEL_RR;
        else             vsel = VSEL_FREE;
        unique case (vsel)
            VSEL_MATCH: wr_way = f_way;
            VSEL_FREE:  wr_way = f_victim;
            VSEL_RR:    wr_way = rr_q[f_idx];
            default:    wr_way = f_victim;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_valid) begin
            vld_q[f_idx][wr_way] <= 1'b1;
            if (vsel == VSEL_RR) begin
                rr_q[f_idx] <= (rr_q[f_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[f_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_fill) begin
            tag_q[f_idx][wr_way] <= fill_vpn[VPN_W-1:IDX_W];
            pid_q[f_idx][wr_way] <= fill_pid;
            ppn_q[f_idx][wr_way] <= fill_ppn;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{lk_way, f_old_ppn};
endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20,
    parameter int PID_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input logic [PID_W-1:0]       lk_pid,
    input logic                   hit,
    input logic [PPN_W+OFF_W-1:0] paddr,
    input logic                   miss_req,
    input logic [VPN_W-1:0]       miss_vpn,
    input logic                   fill_valid,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic [PID_W-1:0]       fill_pid,
    input logic [PPN_W-1:0]       fill_ppn,
    input logic                   flush
);
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PPN_W + OFF_W;

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]); // R1

    AST_MISS_NAMES_VPN: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> (lk_valid && !hit && miss_vpn == lk_vaddr[VA_W-1:OFF_W])); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!hit && !miss_req)); // R3

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (!(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn) && lk_pid == $past(fill_pid))
             || (hit && paddr[PA_W-1:OFF_W] == $past(fill_ppn)))); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit); // R9
endmodule

bind ptag_tlb ptag_tlb_chk #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PID_W(PID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_pid(lk_pid), .hit(hit), .paddr(paddr), .miss_req(miss_req),
    .miss_vpn(miss_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_ppn(fill_ppn), .flush(flush)
);

// File: tb/ptag_tlb_tb.sv
module ptag_tlb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W = 20;
    localparam int OFF_W = 12;
    localparam int PPN_W = 20;
    localparam int PID_W = 8;

    typedef struct packed {
        logic [1:0]  op;    // 0 lookup, 1 refill, 2 flush
        logic [7:0]  pid;
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd1, 20'h00010, 20'h00000, 1'b0, 4'd9},  // R9 empty after reset
        '{2'd1, 8'd1, 20'h00010, 20'h11111, 1'b0, 4'd6},  // R6 way0
        '{2'd0, 8'd1, 20'h00010, 20'h11111, 1'b1, 4'd1},  // R1
        '{2'd0, 8'd2, 20'h00010, 20'h00000, 1'b0, 4'd2},  // R2 other process
        '{2'd1, 8'd2, 20'h00010, 20'h22222, 1'b0, 4'd6},  // R6 way1
        '{2'd0, 8'd1, 20'h00010, 20'h11111, 1'b1, 4'd2},  // R2
        '{2'd0, 8'd2, 20'h00010, 20'h22222, 1'b1, 4'd2},  // R2
        '{2'd1, 8'd1, 20'h00010, 20'h33333, 1'b0, 4'd5},  // R5 update
        '{2'd0, 8'd1, 20'h00010, 20'h33333, 1'b1, 4'd5},  // R5
        '{2'd1, 8'd1, 20'h00020, 20'hBBBBB, 1'b0, 4'd6},  // R6 way2
        '{2'd1, 8'd1, 20'h00030, 20'hCCCCC, 1'b0, 4'd6},  // R6 way3
        '{2'd1, 8'd1, 20'h00040, 20'hDDDDD, 1'b0, 4'd7},  // R7 evicts way0
        '{2'd0, 8'd1, 20'h00010, 20'h00000, 1'b0, 4'd7},  // R7
        '{2'd0, 8'd2, 20'h00010, 20'h22222, 1'b1, 4'd7},  // R7
        '{2'd0, 8'd1, 20'h00040, 20'hDDDDD, 1'b1, 4'd7},  // R7
        '{2'd1, 8'd1, 20'h00050, 20'hEEEEE, 1'b0, 4'd7},  // R7 evicts way1
        '{2'd0, 8'd2, 20'h00010, 20'h00000, 1'b0, 4'd7},  // R7
        '{2'd0, 8'd1, 20'h00020, 20'hBBBBB, 1'b1, 4'd7},  // R7
        '{2'd0, 8'd1, 20'h00050, 20'hEEEEE, 1'b1, 4'd7},  // R7
        '{2'd1, 8'd1, 20'h00011, 20'h44444, 1'b0, 4'd10}, // R10 set1
        '{2'd0, 8'd1, 20'h00011, 20'h44444, 1'b1, 4'd10}, // R10
        '{2'd0, 8'd1, 20'h00015, 20'h00000, 1'b0, 4'd1},  // R1 tag differs
        '{2'd0, 8'd1, 20'h00410, 20'h00000, 1'b0, 4'd1},  // R1 tag differs
        '{2'd2, 8'd0, 20'h00000, 20'h00000, 1'b0, 4'd8},  // R8 flush
        '{2'd0, 8'd1, 20'h00020, 20'h00000, 1'b0, 4'd8},  // R8
        '{2'd0, 8'd1, 20'h00011, 20'h00000, 1'b0, 4'd8},  // R8
        '{2'd0, 8'd1, 20'h00050, 20'h00000, 1'b0, 4'd8},  // R8
        '{2'd1, 8'd3, 20'h00020, 20'h55555, 1'b0, 4'd6},  // R6
        '{2'd0, 8'd3, 20'h00020, 20'h55555, 1'b1, 4'd4}   // R4
    };

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   lk_valid;
    logic [VPN_W+OFF_W-1:0] lk_vaddr;
    logic [PID_W-1:0]       lk_pid;
    logic                   hit;
    logic [PPN_W+OFF_W-1:0] paddr;
    logic                   miss_req;
    logic [VPN_W-1:0]       miss_vpn;
    logic                   fill_valid;
    logic [VPN_W-1:0]       fill_vpn;
    logic [PID_W-1:0]       fill_pid;
    logic [PPN_W-1:0]       fill_ppn;
    logic                   flush;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptag_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_pid(lk_pid), .hit(hit), .paddr(paddr), .miss_req(miss_req),
        .miss_vpn(miss_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pid(fill_pid), .fill_ppn(fill_ppn), .flush(flush)
    );

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_vaddr = '0; lk_pid = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pid = '0; fill_ppn = '0;
        flush = 1'b0;
    endtask

    // compares hit, miss_req and the address carried by whichever is high
    task automatic check_lookup(string tag, logic exp_hit, logic [PPN_W-1:0] exp_ppn);
        logic [PPN_W+OFF_W+VPN_W+1:0] act, exp;
        act = {hit, miss_req, hit ? paddr : '0, miss_req ? miss_vpn : '0};
        exp = {exp_hit, lk_valid && !exp_hit,
               exp_hit ? {exp_ppn, lk_vaddr[OFF_W-1:0]} : '0,
               (lk_valid && !exp_hit) ? lk_vaddr[VPN_W+OFF_W-1:OFF_W] : '0};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: no request, nothing raised
        #1 check_lookup("R3 idle", 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            case (VEC[i].op)
                2'd0: begin
                    lk_valid = 1'b1;
                    lk_pid   = VEC[i].pid;
                    lk_vaddr = {VEC[i].vpn, 12'((i * 291) & 12'hFFF)};
                    #1 check_lookup($sformatf("R%0d vec%0d", VEC[i].req, i),
                                    VEC[i].exp_hit, VEC[i].ppn);
                end
                2'd1: begin
                    fill_valid = 1'b1;
                    fill_vpn   = VEC[i].vpn;
                    fill_pid   = VEC[i].pid;
                    fill_ppn   = VEC[i].ppn;
                end
                default: flush = 1'b1;
            endcase
        end

        // R4: lookup alongside its own refill sees old contents, then hits
        @(negedge clk);
        idle_inputs();
        fill_valid = 1'b1; fill_vpn = 20'h00777; fill_pid = 8'd4; fill_ppn = 20'h77777;
        lk_valid = 1'b1; lk_vaddr = {20'h00777, 12'hABC}; lk_pid = 8'd4;
        #1 check_lookup("R4 same cycle", 1'b0, '0);
        @(negedge clk);
        fill_valid = 1'b0;
        #1 check_lookup("R4 next cycle", 1'b1, 20'h77777);

        // R8: refill coinciding with flush is discarded
        @(negedge clk);
        idle_inputs();
        flush = 1'b1;
        fill_valid = 1'b1; fill_vpn = 20'h00888; fill_pid = 8'd5; fill_ppn = 20'h88888;
        @(negedge clk);
        idle_inputs();
        lk_valid = 1'b1; lk_vaddr = {20'h00888, 12'h001}; lk_pid = 8'd5;
        #1 check_lookup("R8 flush wins", 1'b0, '0);
        lk_vaddr = {20'h00777, 12'h002}; lk_pid = 8'd4;
        #1 check_lookup("R8 prior entry gone", 1'b0, '0);

        // R9: reset in mid-run empties the array
        @(negedge clk);
        idle_inputs();
        fill_valid = 1'b1; fill_vpn = 20'h00999; fill_pid = 8'd6; fill_ppn = 20'h99999;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lk_valid = 1'b1; lk_vaddr = {20'h00999, 12'h010}; lk_pid = 8'd6;
        #1 check_lookup("R9 after reset", 1'b0, '0);

        @(negedge clk);
        idle_inputs();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule